// File: doc/BRIEF.md
# Windowed Light-Level Interrupt with Persistence Filter

This block watches a stream of 16-bit clear-channel light samples. Each sample arrives with a one-cycle valid strobe. The block checks each sample against a programmable window that a lower bound and an upper bound define. A run of consecutive samples that fall outside the window is counted. When the run reaches a programmable length, a sticky interrupt flag is raised. The flag stays set until a clear command pulse arrives.

The flag is always evaluated and is always visible on a raw status output. A separate output-enable input only decides whether the flag also drives the interrupt pin. A 4-bit persistence selector chooses the run length. Its lowest setting makes every completed sample raise the flag. The window is only meaningful when the lower bound is below the upper bound.

Top module: `luxWindowIrq`

## Requirements
- R1: After reset, `statusFlag` and `irqPin` are 0 and the consecutive out-of-window count is 0.
- R2: A valid sample is out of window when it is strictly below `lowBound` or strictly above `highBound`. A sample equal to either bound is inside the window.
- R3: For `persistSel` values 1, 2 and 3, the flag is raised by the valid sample that completes a run of that many consecutive out-of-window samples. For a value n from 4 to 15, the run length is 5×(n−3), so 5, 10, up to 60.
- R4: When `persistSel` is 0, every valid sample raises the flag, whether it is inside or outside the window.
- R5: A valid sample inside the window resets the consecutive count to 0. Cycles with `sampleValid` low do not change the count.
- R6: The flag rises on the clock edge that captures the qualifying sample. It then stays set until a cycle with `clearCmd` high, and it reads 0 from the next edge on.
- R7: If `clearCmd` and a qualifying sample fall in the same cycle, the flag is set.
- R8: The count saturates at the run length. After a clear, one more out-of-window sample in an unbroken run raises the flag again on its own edge.
- R9: `irqPin` equals `statusFlag` while `irqEnable` is 1 and is 0 otherwise. `statusFlag` does not depend on `irqEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a completed sample |
| sampleData | input | 16 | Clear-channel light sample |
| lowBound | input | 16 | Lower edge of the window |
| highBound | input | 16 | Upper edge of the window |
| persistSel | input | 4 | Persistence selector, encoded as in R3 and R4 |
| irqEnable | input | 1 | Gates the flag onto the interrupt pin |
| clearCmd | input | 1 | Clears the sticky flag |
| statusFlag | output | 1 | Raw sticky interrupt flag |
| irqPin | output | 1 | Gated interrupt output |

## Verification
The hardest state to reach is a saturated count with the flag just cleared. It needs a run as long as 60 samples, a clear while the run continues, and then one more out-of-window sample. The bench sweeps all sixteen persistence settings. For each one it drives a run three samples past the run length, clears in mid-run, and then sends another sample. It also hits the set-versus-clear collision and an in-range sample that breaks a run one short of the limit.

// File: rtl/luxIrqPkg.sv
package luxIrqPkg;

  // Strobes from the control unit to the counting datapath
  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
  } cntStrobe_t;

endpackage

// File: rtl/luxIrqDatapath.sv
module luxIrqDatapath
  import luxIrqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [DATA_W-1:0] lowBound,
  input  logic [DATA_W-1:0] highBound,
  input  logic [CNT_W-1:0]  targetCount,
  input  cntStrobe_t        strobes,
  output logic              outOfWindow,
  output logic [CNT_W-1:0]  nextCount
);

  logic [CNT_W-1:0] runCount;
  logic             belowLow;
  logic             aboveHigh;

  // Window comparison: equality with a bound counts as inside
  always_comb begin
    belowLow    = sampleData < lowBound;
    aboveHigh   = sampleData > highBound;
    outOfWindow = belowLow || aboveHigh;
  end

  // Saturating increment: never passes the run length
  always_comb begin
    if (runCount >= targetCount) nextCount = targetCount;
    else                         nextCount = runCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   runCount <= '0;
    else if (strobes.cntClear)   runCount <= '0;
    else if (strobes.cntAdvance) runCount <= nextCount;
  end

  // R5: without a strobe the count holds
  a_r5_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntClear && !strobes.cntAdvance) |=> $stable(runCount));

  // R8: an advance never moves the count past the run length
  a_r8_saturates: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntAdvance |=> (runCount <= $past(targetCount)));

endmodule

// File: rtl/luxIrqControl.sv
module luxIrqControl
  import luxIrqPkg::*;
#(
  parameter int PERS_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              outOfWindow,
  input  logic [CNT_W-1:0]  nextCount,
  input  logic [PERS_W-1:0] persistSel,
  input  logic              clearCmd,
  output logic [CNT_W-1:0]  targetCount,
  output cntStrobe_t        strobes,
  output logic              statusFlag
);

  logic everySample;
  logic runComplete;
  logic setEvent;

  // Selector decode: 0..3 map directly, higher codes step by five
  always_comb begin
    if (persistSel <= PERS_W'(3)) targetCount = CNT_W'(persistSel);
    else                          targetCount = CNT_W'(5 * (int'(persistSel) - 3));
  end

  always_comb begin
    everySample         = (persistSel == '0);
    runComplete         = outOfWindow && (nextCount >= targetCount);
    setEvent            = sampleValid && (everySample || runComplete);
    strobes.cntClear    = sampleValid && !outOfWindow;
    strobes.cntAdvance  = sampleValid && outOfWindow;
  end

  // Sticky flag: a set beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         statusFlag <= 1'b0;
    else if (setEvent) statusFlag <= 1'b1;
    else if (clearCmd) statusFlag <= 1'b0;
  end

  // R6: the flag stays up until a clear command
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlag && !clearCmd) |=> statusFlag);

  // R7: a simultaneous set and clear leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setEvent && clearCmd) |=> statusFlag);

  // R4: with selector zero every valid sample raises the flag
  a_r4_every_sample: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && persistSel == '0) |=> statusFlag);

  // R6: a clear with no sample drops the flag
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && !sampleValid) |=> !statusFlag);

endmodule

// File: rtl/luxWindowIrq.sv
module luxWindowIrq
  import luxIrqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [DATA_W-1:0] lowBound,
  input  logic [DATA_W-1:0] highBound,
  input  logic [PERS_W-1:0] persistSel,
  input  logic              irqEnable,
  input  logic              clearCmd,
  output logic              statusFlag,
  output logic              irqPin
);

  localparam int MAX_RUN = 5 * ((1 << PERS_W) - 4);
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  cntStrobe_t       strobes;
  logic             outOfWindow;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] targetCount;

  luxIrqDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleData (sampleData),
    .lowBound   (lowBound),
    .highBound  (highBound),
    .targetCount(targetCount),
    .strobes    (strobes),
    .outOfWindow(outOfWindow),
    .nextCount  (nextCount)
  );

  luxIrqControl #(.PERS_W(PERS_W), .CNT_W(CNT_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .outOfWindow(outOfWindow),
    .nextCount  (nextCount),
    .persistSel (persistSel),
    .clearCmd   (clearCmd),
    .targetCount(targetCount),
    .strobes    (strobes),
    .statusFlag (statusFlag)
  );

  always_comb irqPin = statusFlag && irqEnable;

  // R9: a disabled output never asserts the pin
  always_comb begin
    if (rstN && !irqEnable) a_r9_gate: assert (!irqPin);
  end

endmodule

// File: tb/luxWindowIrq_tb.sv
module luxWindowIrq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [15:0] lowBound = 16'd100;
  logic [15:0] highBound = 16'd200;
  logic [3:0]  persistSel = '0;
  logic        irqEnable = 1'b1;
  logic        clearCmd = 1'b0;
  logic        statusFlag;
  logic        irqPin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  int expCount = 0;
  bit expFlag = 0;

  always #10 clk = ~clk;

  luxWindowIrq u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .lowBound(lowBound), .highBound(highBound), .persistSel(persistSel),
    .irqEnable(irqEnable), .clearCmd(clearCmd),
    .statusFlag(statusFlag), .irqPin(irqPin)
  );

  function automatic int runLen(input int sel);
    if (sel <= 3) return sel;
    return 5 * (sel - 3);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drives one cycle, advances the reference model, then compares outputs
  task automatic step(input bit v, input logic [15:0] d, input bit clr, input string tag);
    bit oor;
    bit setEv;
    int tgt;
    int nxt;
    @(negedge clk);
    sampleValid = v; sampleData = d; clearCmd = clr;
    @(posedge clk);
    tgt = runLen(int'(persistSel));
    oor = (d < lowBound) || (d > highBound);
    nxt = (expCount >= tgt) ? tgt : expCount + 1;
    setEv = v && ((persistSel == 0) || (oor && nxt >= tgt));
    if (v) expCount = oor ? nxt : 0;
    if (setEv) expFlag = 1;
    else if (clr) expFlag = 0;
    #1;
    check(statusFlag, expFlag, tag);
    check(irqPin, expFlag && irqEnable, {tag, " R9 pin"});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    check(statusFlag, 1'b0, "R1 reset flag");
    check(irqPin, 1'b0, "R1 reset pin");
    rstN = 1'b1;

    // R1: reset count is zero, so selector 1 fires on the first outside sample
    persistSel = 4'd1;
    step(1, 16'd50, 0, "R1 count zero after reset");
    step(0, 16'd0, 1, "R6 clear");

    // R2: boundary sweep around both bounds with selector 1
    for (int d = 96; d <= 204; d++) begin
      step(1, 16'(d), 0, "R2 window edge");
      step(0, 16'(d), 1, "R2 clear");
    end
    step(1, 16'd0, 0, "R2 zero sample");
    step(0, 16'd0, 1, "R2 clear");
    step(1, 16'hFFFF, 0, "R2 max sample");
    step(0, 16'd0, 1, "R2 clear");

    // R3, R4, R5, R8: sweep every selector
    for (int s = 0; s < 16; s++) begin
      persistSel = 4'(s);
      irqEnable = s[0];
      step(1, 16'd150, 1, "R5 in-window resets run");
      step(0, 16'd0, 1, "R6 clear");
      // a run one short, broken by an in-window sample, raises nothing
      for (int k = 1; k < runLen(s); k++) step(1, 16'd10, 0, "R3 short run");
      step(0, 16'd10, 0, "R5 idle cycle ignored");
      step(1, 16'd150, 0, "R5 break");
      step(0, 16'd0, 1, "R4 clear");
      // full run plus three extra samples
      for (int k = 0; k < runLen(s) + 3; k++) step(1, 16'd300, 0, "R3 run");
      step(0, 16'd0, 0, "R6 sticky idle");
      step(0, 16'd0, 1, "R6 clear");
      step(0, 16'd0, 0, "R6 stays cleared");
      step(1, 16'd5, 0, "R8 saturated re-raise");
      step(1, 16'd5, 1, "R7 set beats clear");
      step(0, 16'd5, 1, "R6 clear");
    end

    // R9: toggling the enable with the flag held
    persistSel = 4'd0;
    irqEnable = 1'b0;
    step(1, 16'd150, 0, "R9 flag with pin off");
    irqEnable = 1'b1;
    step(0, 16'd0, 0, "R9 pin follows enable");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule